// File: doc/BRIEF.md
# Two-Channel Timer with PWM

A 16-bit timer with one shared counter, a modulo limit and two channels. A prescaler divides an incoming source tick by a power of two and advances the counter. A global center-select bit sets how the counter moves. When the bit is clear, the counter counts up from zero to the modulo limit and wraps. In that setting each channel is set up on its own as input capture, output compare or buffered edge-aligned PWM. When the bit is set, the counter runs up to the limit and back down to zero. Every channel then drives center-aligned PWM, whatever its own mode field holds.

Software reaches the block through a flat register port with a write strobe, an address and a combinational read path. The modulo limit and the PWM duty values are double-buffered while the timer runs. New values take effect only at a reload point, so a period in progress is never cut short. An overflow flag and one flag per channel each stay set until written with a one. A single interrupt line combines every flag whose enable bit is set.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset the count reads 0, all flags are clear, both channel pins are low and the interrupt output is low.
- R2: The timer advances once every 2^PS source ticks, where PS is the 3-bit field CTRL[4:2]. It holds its value while the run bit CTRL[0] is 0. Any write to COUNT (address 2) clears the count.
- R3: With CTRL[1]=0 the count goes 0,1,..,MOD,0 and the overflow flag (STAT[0]) is set on the step back to 0. MOD=0 selects a full 16-bit free run that wraps after 0xFFFF.
- R4: A MOD write (address 3) while running takes effect only at the next reload point. A MOD write while stopped takes effect at once. Reading MOD returns the limit currently in use.
- R5: With CTRL[1]=1 the count goes up to MOD and then down to 0, with a period of 2*MOD ticks. The overflow flag is set when the count reaches 0. That reaching of 0 is the reload point. Changes to CTRL[1] are ignored while running.
- R6: In PWM the pin is high while count < duty if the channel polarity bit CFG[4] is 1, and is the inverse if that bit is 0. With CTRL[1]=1 both channels act as PWM whatever their mode field holds.
- R7: In edge PWM or center mode, a duty write (channel value register) while running is buffered until the reload point. Reading the value register returns the duty currently in use.
- R8: Channel mode CFG[1:0]=2 is output compare. When the count equals the channel value on a timer tick, the channel flag is set and the pin changes by CFG[3:2]: 0 toggles, 1 clears, 2 sets, 3 leaves the pin unchanged.
- R9: Channel mode CFG[1:0]=1 is input capture, and CFG[3:2] selects the edges: 1 rising, 2 falling, 3 both. On a selected edge the value register latches the count and the flag is set, three clock edges after the pin changes. Edges that are not selected change nothing.
- R10: Flags are cleared by writing a 1 to STAT (address 1): bit 0 for overflow, bit 1+i for channel i. A set on the same edge wins over the clear.
- R11: irq_o is high when the overflow flag is set with CTRL[5]=1, or when a channel flag is set with that channel's CFG[5]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 1 | Source clock enable before the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address (0 CTRL, 1 STAT, 2 COUNT, 3 MOD, 4+2i channel config, 5+2i channel value) |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i |
| ch_pin_i | input | 2 | Channel capture inputs |
| ch_pin_o | output | 2 | Channel compare/PWM outputs |
| ch_flag_o | output | 2 | Channel event flags |
| ovf_flag_o | output | 1 | Counter overflow flag |
| irq_o | output | 1 | Combined enabled interrupt |

## Verification
A counter that takes a wrong step or misses a wrap shows up in the COUNT readback and in the overflow flag within one timer period. The PWM pins show a wrong duty or a reload at the wrong point in the same period, and the value readback shows it too. The bench therefore compares count, pins and flags cycle by cycle across whole periods. It does this for edge and center modes, and for buffered changes made in the middle of a period. A fault in a capture synchronizer or in a compare action shows up in the latched value or on the pin three edges after the stimulus, or one edge after it.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  typedef enum logic [1:0] {
    CH_OFF = 2'd0,
    CH_CAP = 2'd1,
    CH_CMP = 2'd2,
    CH_PWM = 2'd3
  } ch_mode_e;

  typedef struct packed {
    logic       ie;
    logic       pol;
    logic [1:0] act;
    ch_mode_e   mode;
  } ch_cfg_t;

  localparam int unsigned CFG_W     = 6;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_CNT  = 2;
  localparam int unsigned ADDR_MOD  = 3;
  localparam int unsigned ADDR_CH0  = 4;
endpackage

// File: rtl/dtp_prescaler.sv
module dtp_prescaler #(
  parameter int unsigned PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           clr_i,
  input  logic           src_tick_i,
  input  logic [PSW-1:0] ps_i,
  output logic           tick_o
);
  localparam int unsigned DW = (1 << PSW) - 1;

  logic [DW-1:0] div_q;
  logic [DW:0]   one_sh;
  logic [DW-1:0] mask;

  assign one_sh = (DW+1)'(1) << ps_i;
  assign mask   = one_sh[DW-1:0] - DW'(1);
  assign tick_o = en_i & src_tick_i & ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (clr_i || !en_i)  div_q <= '0;
    else if (src_tick_i)      div_q <= div_q + DW'(1);
  end
endmodule

// File: rtl/dtp_counter.sv
module dtp_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic          center_i,
  input  logic          run_i,
  input  logic          mod_wr_i,
  input  logic [CW-1:0] mod_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] mod_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, cnt_d, mod_q, mod_buf_q;
  logic          down_q, down_d, wrap;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    wrap   = 1'b0;
    if (center_i) begin
      if (mod_q == '0) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else if (!down_q) begin
        if (cnt_q >= mod_q) begin
          if (cnt_q <= CW'(1)) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else begin
            cnt_d  = cnt_q - CW'(1);
            down_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else if (cnt_q <= CW'(1)) begin
        cnt_d  = '0;
        down_d = 1'b0;
        wrap   = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else begin
      down_d = 1'b0;
      if ((mod_q != '0 && cnt_q >= mod_q) || cnt_q == '1) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  // limit is double-buffered only while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q     <= '0;
      mod_buf_q <= '0;
    end else begin
      if (mod_wr_i) mod_buf_q <= mod_i;
      if (mod_wr_i && !run_i)   mod_q <= mod_i;
      else if (tick_i && wrap)  mod_q <= mod_buf_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign mod_o  = mod_q;
  assign wrap_o = tick_i & wrap;
endmodule

// File: rtl/dtp_channel.sv
module dtp_channel import dtp_pkg::*; #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          center_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          reload_i,
  input  logic [CW-1:0] cnt_i,
  input  ch_cfg_t       cfg_i,
  input  logic          val_wr_i,
  input  logic [CW-1:0] val_i,
  input  logic          pin_i,
  input  logic          flag_clr_i,
  output logic          pin_o,
  output logic [CW-1:0] val_o,
  output logic          flag_o
);
  logic [2:0]    sync_q;
  logic [CW-1:0] act_q, buf_q;
  logic          oc_q, flag_q;
  logic          rise, fall, cap_mode, cmp_mode, pwm_mode, cap_hit, match, below;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign fall     = ~sync_q[1] & sync_q[2];
  assign cap_mode = !center_i && cfg_i.mode == CH_CAP;
  assign cmp_mode = !center_i && cfg_i.mode == CH_CMP;
  assign pwm_mode = center_i || cfg_i.mode == CH_PWM;
  assign cap_hit  = cap_mode && ((cfg_i.act[0] && rise) || (cfg_i.act[1] && fall));
  assign match    = tick_i && (cnt_i == act_q);
  assign below    = cnt_i < act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      buf_q <= '0;
    end else if (cap_hit) begin
      act_q <= cnt_i;
      buf_q <= cnt_i;
    end else begin
      if (val_wr_i) begin
        buf_q <= val_i;
        if (!(pwm_mode && run_i)) act_q <= val_i;
      end
      if (reload_i && pwm_mode) act_q <= buf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oc_q <= 1'b0;
    else if (cmp_mode && match) begin
      unique case (cfg_i.act)
        2'd0:    oc_q <= ~oc_q;
        2'd1:    oc_q <= 1'b0;
        2'd2:    oc_q <= 1'b1;
        default: oc_q <= oc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     flag_q <= 1'b0;
    else if (cap_hit || (match && (cmp_mode || pwm_mode))) flag_q <= 1'b1;
    else if (flag_clr_i)                             flag_q <= 1'b0;
  end

  always_comb begin
    if (pwm_mode)      pin_o = cfg_i.pol ? below : ~below;
    else if (cmp_mode) pin_o = oc_q;
    else               pin_o = 1'b0;
  end

  assign val_o  = act_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm import dtp_pkg::*; #(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 2,
  parameter int unsigned PSW = 3,
  parameter int unsigned AW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           src_tick_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CW-1:0]  wdata_i,
  output logic [CW-1:0]  rdata_o,
  input  logic [NCH-1:0] ch_pin_i,
  output logic [NCH-1:0] ch_pin_o,
  output logic [NCH-1:0] ch_flag_o,
  output logic           ovf_flag_o,
  output logic           irq_o
);
  localparam int unsigned IE_BIT = 2 + PSW;

  logic           run_q, center_q, ovf_ie_q, ovf_q;
  logic [PSW-1:0] ps_q;
  logic           ctrl_wr, stat_wr, cnt_wr, mod_wr, tick, wrap;
  logic [CW-1:0]  cnt, mod_act;
  logic [NCH-1:0] cfg_wr, val_wr, ch_ie;
  ch_cfg_t        cfg_q [NCH];
  logic [CW-1:0]  ch_val [NCH];

  assign ctrl_wr = wr_en_i && addr_i == AW'(ADDR_CTRL);
  assign stat_wr = wr_en_i && addr_i == AW'(ADDR_STAT);
  assign cnt_wr  = wr_en_i && addr_i == AW'(ADDR_CNT);
  assign mod_wr  = wr_en_i && addr_i == AW'(ADDR_MOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      center_q <= 1'b0;
      ps_q     <= '0;
      ovf_ie_q <= 1'b0;
    end else if (ctrl_wr) begin
      run_q    <= wdata_i[0];
      center_q <= run_q ? center_q : wdata_i[1];
      ps_q     <= wdata_i[2 +: PSW];
      ovf_ie_q <= wdata_i[IE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovf_q <= 1'b0;
    else if (wrap)                   ovf_q <= 1'b1;
    else if (stat_wr && wdata_i[0])  ovf_q <= 1'b0;
  end

  dtp_prescaler #(.PSW(PSW)) u_pre (
    .clk_i, .rst_ni,
    .en_i       (run_q),
    .clr_i      (cnt_wr),
    .src_tick_i,
    .ps_i       (ps_q),
    .tick_o     (tick)
  );

  dtp_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .clr_i    (cnt_wr),
    .center_i (center_q),
    .run_i    (run_q),
    .mod_wr_i (mod_wr),
    .mod_i    (wdata_i),
    .cnt_o    (cnt),
    .mod_o    (mod_act),
    .wrap_o   (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg_wr[i] = wr_en_i && addr_i == AW'(ADDR_CH0 + 2*i);
    assign val_wr[i] = wr_en_i && addr_i == AW'(ADDR_CH0 + 2*i + 1);
    assign ch_ie[i]  = cfg_q[i].ie;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cfg_q[i] <= '0;
      else if (cfg_wr[i]) cfg_q[i] <= ch_cfg_t'(wdata_i[CFG_W-1:0]);
    end

    dtp_channel #(.CW(CW)) u_ch (
      .clk_i, .rst_ni,
      .center_i   (center_q),
      .run_i      (run_q),
      .tick_i     (tick),
      .reload_i   (wrap),
      .cnt_i      (cnt),
      .cfg_i      (cfg_q[i]),
      .val_wr_i   (val_wr[i]),
      .val_i      (wdata_i),
      .pin_i      (ch_pin_i[i]),
      .flag_clr_i (stat_wr && wdata_i[1+i]),
      .pin_o      (ch_pin_o[i]),
      .val_o      (ch_val[i]),
      .flag_o     (ch_flag_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_CTRL))      rdata_o = CW'({ovf_ie_q, ps_q, center_q, run_q});
    else if (addr_i == AW'(ADDR_STAT)) rdata_o = CW'({ch_flag_o, ovf_q});
    else if (addr_i == AW'(ADDR_CNT))  rdata_o = cnt;
    else if (addr_i == AW'(ADDR_MOD))  rdata_o = mod_act;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == AW'(ADDR_CH0 + 2*i))     rdata_o = CW'(cfg_q[i]);
      if (addr_i == AW'(ADDR_CH0 + 2*i + 1)) rdata_o = ch_val[i];
    end
  end

  assign ovf_flag_o = ovf_q;
  assign irq_o      = (ovf_q & ovf_ie_q) | |(ch_flag_o & ch_ie);
endmodule

// File: rtl/dual_timer_pwm_chk.sv
module dual_timer_pwm_chk #(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run_i,
  input logic           cnt_wr_i,
  input logic [CW-1:0]  cnt_i,
  input logic [CW-1:0]  mod_i,
  input logic           reload_i,
  input logic           ovf_i,
  input logic           stat_wr_i,
  input logic [CW-1:0]  wdata_i,
  input logic [NCH-1:0] flag_i,
  input logic           irq_i
);
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !cnt_wr_i |=> $stable(cnt_i)); // R2
  AST_OVF_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> cnt_i == '0); // R3
  AST_MOD_BUFFERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !reload_i |=> $stable(mod_i)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i && !(stat_wr_i && wdata_i[0]) |=> ovf_i); // R10
  for (genvar i = 0; i < NCH; i++) begin : g_flag
    AST_CH_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_i[i] && !(stat_wr_i && wdata_i[1+i]) |=> flag_i[i]); // R10
  end
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_i && flag_i == '0 |-> !irq_i); // R11
endmodule

bind dual_timer_pwm dual_timer_pwm_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_q),
  .cnt_wr_i  (cnt_wr),
  .cnt_i     (cnt),
  .mod_i     (mod_act),
  .reload_i  (wrap),
  .ovf_i     (ovf_flag_o),
  .stat_wr_i (stat_wr),
  .wdata_i   (wdata_i),
  .flag_i    (ch_flag_o),
  .irq_i     (irq_o)
);

// File: tb/dual_timer_pwm_test.sv
module dual_timer_pwm_test;
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_CNT = 4'd2, A_MOD = 4'd3,
                         A_C0CFG = 4'd4, A_C0VAL = 4'd5, A_C1CFG = 4'd6, A_C1VAL = 4'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  pin_in = '0;
  logic [1:0]  pin_out, flags;
  logic        ovf, irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dual_timer_pwm uut (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ch_pin_i(pin_in), .ch_pin_o(pin_out), .ch_flag_o(flags),
    .ovf_flag_o(ovf), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge (one posedge consumed)
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_clear();
    wr(A_CTRL, 16'h0); wr(A_CNT, 16'h0);
    wr(A_C0CFG, 16'h0); wr(A_C1CFG, 16'h0);
    wr(A_STAT, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_CNT, v);  chk("R1 count", v, 16'h0);
    rd(A_STAT, v); chk("R1 flags", v, 16'h0);
    chk("R1 pins", {14'h0, pin_out}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    stop_clear(); wr(A_MOD, 16'h0);
    wr(A_CTRL, 16'h0001);
    edges(5); rd(A_CNT, v); chk("R2 div1", v, 16'd5);
    stop_clear(); wr(A_MOD, 16'h0);
    wr(A_CTRL, 16'h0009); // run, PS=2
    edges(19); rd(A_CNT, v); chk("R2 div4 a", v, 16'd4);
    edges(1);  rd(A_CNT, v); chk("R2 div4 b", v, 16'd5);
    wr(A_CTRL, 16'h0008);
    edges(6);  rd(A_CNT, v); chk("R2 hold", v, 16'd5);
    wr(A_CNT, 16'h1234);
    rd(A_CNT, v); chk("R2 clear", v, 16'd0);
  endtask

  task automatic t_modulo();
    logic [15:0] v;
    stop_clear(); wr(A_MOD, 16'd4);
    wr(A_CTRL, 16'h0001);
    edges(4); rd(A_CNT, v); chk("R3 top", v, 16'd4);
    chk("R3 no ovf", {15'h0, ovf}, 16'h0);
    edges(1); rd(A_CNT, v); chk("R3 wrap", v, 16'd0);
    chk("R3 ovf", {15'h0, ovf}, 16'h1);
    wr(A_MOD, 16'd2);
    edges(3); rd(A_CNT, v); chk("R4 old limit", v, 16'd4);
    rd(A_MOD, v); chk("R4 mod read old", v, 16'd4);
    edges(1); rd(A_CNT, v); chk("R4 wrap", v, 16'd0);
    rd(A_MOD, v); chk("R4 mod read new", v, 16'd2);
    edges(2); rd(A_CNT, v); chk("R4 new top", v, 16'd2);
    edges(1); rd(A_CNT, v); chk("R4 new wrap", v, 16'd0);
  endtask

  task automatic t_freerun();
    logic [15:0] v;
    stop_clear(); wr(A_MOD, 16'h0);
    wr(A_CTRL, 16'h0001);
    edges(65535); rd(A_CNT, v); chk("R3 free top", v, 16'hFFFF);
    chk("R3 free no ovf", {15'h0, ovf}, 16'h0);
    edges(1); rd(A_CNT, v); chk("R3 free wrap", v, 16'h0);
    chk("R3 free ovf", {15'h0, ovf}, 16'h1);
  endtask

  task automatic t_flags();
    stop_clear(); wr(A_MOD, 16'd4);
    wr(A_CTRL, 16'h0021);
    edges(5);
    chk("R11 irq on", {15'h0, irq}, 16'h1);
    wr(A_STAT, 16'h0001);
    chk("R10 clear", {15'h0, ovf}, 16'h0);
    chk("R11 irq off", {15'h0, irq}, 16'h0);
    edges(3);
    wr(A_STAT, 16'h0001); // lands on the wrap edge
    chk("R10 set wins", {15'h0, ovf}, 16'h1);
  endtask

  task automatic t_center();
    int exp;
    stop_clear(); wr(A_MOD, 16'd4);
    wr(A_C0CFG, 16'h0010); // mode off, polarity high: still PWM in center mode
    wr(A_C0VAL, 16'd2);
    wr(A_CTRL, 16'h0003);
    chk("R6 center start pin", {15'h0, pin_out[0]}, 16'h1);
    for (int n = 1; n <= 9; n++) begin
      logic [15:0] v;
      edges(1);
      exp = (n <= 4) ? n : ((n <= 8) ? 8 - n : n - 8);
      rd(A_CNT, v); chk("R5 center count", v, 16'(exp));
      chk("R6 center pin", {15'h0, pin_out[0]}, {15'h0, exp < 2});
      if (n == 7) chk("R5 no ovf", {15'h0, ovf}, 16'h0);
      if (n == 8) chk("R5 ovf at zero", {15'h0, ovf}, 16'h1);
    end
  endtask

  task automatic t_edge_pwm();
    logic [15:0] v;
    int c;
    stop_clear(); wr(A_MOD, 16'd4);
    wr(A_C0CFG, 16'h0013); wr(A_C0VAL, 16'd2);
    wr(A_C1CFG, 16'h0003); wr(A_C1VAL, 16'd2);
    wr(A_CTRL, 16'h0001);
    for (int n = 1; n <= 5; n++) begin
      edges(1);
      c = n % 5;
      chk("R6 pwm high-true", {15'h0, pin_out[0]}, {15'h0, c < 2});
      chk("R6 pwm low-true", {15'h0, pin_out[1]}, {15'h0, !(c < 2)});
    end
    wr(A_C0VAL, 16'd3);
    rd(A_C0VAL, v); chk("R7 duty held", v, 16'd2);
    edges(1);
    chk("R7 old duty pin", {15'h0, pin_out[0]}, 16'h0);
    edges(3);
    rd(A_C0VAL, v); chk("R7 duty reloaded", v, 16'd3);
    edges(2);
    chk("R7 new duty pin", {15'h0, pin_out[0]}, 16'h1);
  endtask

  task automatic t_compare();
    stop_clear(); wr(A_MOD, 16'd4);
    wr(A_C0CFG, 16'h000A); wr(A_C0VAL, 16'd3); // set on match
    wr(A_C1CFG, 16'h0002); wr(A_C1VAL, 16'd1); // toggle on match
    wr(A_CTRL, 16'h0001);
    edges(2);
    chk("R8 toggle up", {15'h0, pin_out[1]}, 16'h1);
    chk("R8 set early", {15'h0, pin_out[0]}, 16'h0);
    edges(1);
    chk("R8 flag early", {15'h0, flags[0]}, 16'h0);
    edges(1);
    chk("R8 set pin", {15'h0, pin_out[0]}, 16'h1);
    chk("R8 flag", {15'h0, flags[0]}, 16'h1);
    edges(3);
    chk("R8 toggle down", {15'h0, pin_out[1]}, 16'h0);
    wr(A_C0CFG, 16'h0006); // clear on match
    chk("R8 clear pending", {15'h0, pin_out[0]}, 16'h1);
    edges(1);
    chk("R8 clear pin", {15'h0, pin_out[0]}, 16'h0);
  endtask

  task automatic t_capture();
    logic [15:0] c0, v;
    stop_clear(); wr(A_MOD, 16'h0);
    wr(A_C1CFG, 16'h0005); // capture rising
    wr(A_CTRL, 16'h0001);
    edges(10);
    rd(A_CNT, c0); pin_in[1] = 1'b1;
    edges(2);
    chk("R9 flag latency", {15'h0, flags[1]}, 16'h0);
    edges(1);
    chk("R9 rise flag", {15'h0, flags[1]}, 16'h1);
    rd(A_C1VAL, v); chk("R9 rise value", v, c0 + 16'd2);
    wr(A_STAT, 16'h0004);
    pin_in[1] = 1'b0;
    edges(5);
    chk("R9 falling ignored flag", {15'h0, flags[1]}, 16'h0);
    rd(A_C1VAL, v); chk("R9 falling ignored value", v, c0 + 16'd2);
    wr(A_C1CFG, 16'h000D); // both edges
    rd(A_CNT, c0); pin_in[1] = 1'b1;
    edges(3);
    rd(A_C1VAL, v); chk("R9 both rise", v, c0 + 16'd2);
    wr(A_STAT, 16'h0004);
    rd(A_CNT, c0); pin_in[1] = 1'b0;
    edges(3);
    chk("R9 both fall flag", {15'h0, flags[1]}, 16'h1);
    rd(A_C1VAL, v); chk("R9 both fall", v, c0 + 16'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_prescale();
    t_modulo();
    t_freerun();
    t_flags();
    t_center();
    t_edge_pwm();
    t_compare();
    t_capture();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule